// File: doc/BRIEF.md
# RS-485 Addressed-Slave UART Receiver

This block is the receive side of a UART used as a slave on a multi-drop RS-485 bus. It watches the serial line through a two-flop synchroniser and oversamples it at 16 times the bit rate. It assembles each character from a start bit, eight data bits sent least significant bit first, an optional ninth parity bit and a stop bit. Every finished character is then sent to one of two places.

When parity, even-select and stick-select are all enabled, the ninth bit is expected to be a constant 0. A character whose ninth bit is 1 fails that check. Such a character is taken as an address mark and does not count as a fault. It appears on a dedicated address output with a one-cycle strobe and never enters the data queue. Every other character is a data character and is written into a small first-in first-out queue. Software-visible status is provided by latched parity-mismatch and framing flags and by a sticky overflow flag.

The baud rate comes from a divisor input. One oversampling tick occurs every `cfg_div + 1` clock cycles.

Top module: `rs485_addr_rx`

## Requirements
- R1: After reset the queue is empty (`fifo_empty` = 1, `fifo_level` = 0), and `addr_valid`, `par_err`, `frame_err` and `overflow` are all 0.
- R2: A character begins at a high-to-low transition of `rxd`. Each bit is sampled once, at the middle of a bit time of 16 ticks. Data bits arrive least significant bit first. `rd_data` bit 0 is the first data bit received.
- R3: A low pulse on `rxd` that has ended by the middle of the start bit is discarded. It produces no queue write, no address strobe and no flag change, and a following valid character is still received.
- R4: Address detection is on only when `cfg_par_en`, `cfg_even` and `cfg_stick` are all 1. In that mode the ninth bit must be 0. A received ninth bit of 1 puts the data byte on `addr_data` and raises `addr_valid` for exactly one cycle. That byte is not written to the queue.
- R5: In address-detection mode, a character whose ninth bit is 0 is written to the queue and raises no address strobe.
- R6: With `cfg_par_en` = 0 the frame is 8N1, with no ninth bit. Every character is written to the queue and `addr_valid` stays 0.
- R7: With parity enabled but address detection off, the expected ninth bit is computed as follows. It is the XOR of the data bits when `cfg_even` = 1 and `cfg_stick` = 0. It is the inverse of that XOR when `cfg_even` = 0 and `cfg_stick` = 0. It is the constant 1 when `cfg_even` = 0 and `cfg_stick` = 1. A mismatch still writes the byte to the queue and raises no address strobe.
- R8: `par_err` holds the parity-check result of the most recently completed character. It is 1 on a mismatch and 0 otherwise, and it is always 0 when parity is disabled.
- R9: `frame_err` holds 1 when the most recent character's stop bit was sampled low, and 0 otherwise. The character is still routed exactly as R4 to R7 require.
- R10: The queue holds 4 entries and is show-ahead: `rd_data` is the oldest entry. A cycle with `rd_en` = 1 removes that entry. `rd_en` on an empty queue has no effect.
- R11: A data character that arrives while the queue is full, with no read in the same cycle, is dropped. It sets `overflow`, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial receive line, idle high |
| cfg_par_en | input | 1 | Ninth (parity) bit present and checked |
| cfg_even | input | 1 | Even-parity select |
| cfg_stick | input | 1 | Stick (constant) parity select |
| cfg_div | input | 16 | Tick divisor; tick period is cfg_div+1 clocks |
| rd_en | input | 1 | Remove the oldest queue entry |
| rd_data | output | 8 | Oldest queue entry |
| fifo_level | output | 3 | Number of entries held |
| fifo_empty | output | 1 | Queue holds no entry |
| fifo_full | output | 1 | Queue holds 4 entries |
| addr_valid | output | 1 | One-cycle strobe for a detected address byte |
| addr_data | output | 8 | Last detected address byte |
| par_err | output | 1 | Parity result of the last character |
| frame_err | output | 1 | Stop-bit result of the last character |
| overflow | output | 1 | Sticky: a data character was dropped |

## Verification
Two pairs of functions can coincide, and each pair is tested deliberately.

The first pair is the address strobe and a queue read. The bench holds one data byte in the queue. As soon as `addr_valid` is seen high, it raises `rd_en` within that same strobe cycle. The queue must then lose exactly its one entry and show the data byte that was read. The address byte must appear only on `addr_data`.

The second pair is address detection and the framing check, which both resolve on one character. An address character is sent with a low stop bit. It must produce the strobe and also set `frame_err`, while the queue level stays unchanged.

A behavioural model built from queues predicts every routing decision. The bench compares each address strobe against that model in the clock cycle where the strobe appears.

// File: rtl/rs485_rx_pkg.sv
package rs485_rx_pkg;

  localparam int unsigned RX_DW = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_NINTH,
    ST_STOP
  } rx_state_e;

  // address marks are recognised only with all three parity controls set
  function automatic logic addr_mode(input logic par_en, input logic even, input logic stick);
    return par_en & even & stick;
  endfunction

  // value the ninth bit should carry for a given byte and parity selection
  function automatic logic want_ninth(input logic [RX_DW-1:0] d, input logic even, input logic stick);
    logic x;
    x = ^d;
    if (stick) return ~even;
    return even ? x : ~x;
  endfunction

endpackage

// File: rtl/rs485_rx_baud.sv
module rs485_rx_baud #(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;

  assign tick = (cnt >= div);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (tick) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rs485_rx_deser.sv
module rs485_rx_deser
  import rs485_rx_pkg::*;
#(
  parameter int unsigned OSR = 16,
  parameter int unsigned DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          rxd_raw,
  input  logic          ninth_en,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          ninth,
  output logic          stop_ok,
  output logic          false_start
);
  localparam int unsigned CW  = $clog2(OSR);
  localparam int unsigned BIW = (DW > 1) ? $clog2(DW) : 1;
  localparam logic [CW-1:0]  MID_C  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0]  LAST_C = CW'(OSR - 1);
  localparam logic [BIW-1:0] TOP_B  = BIW'(DW - 1);

  logic            sync1, rxd_s, prev;
  rx_state_e       state;
  logic [CW-1:0]   os_cnt;
  logic [BIW-1:0]  bit_idx;
  logic            at_mid, at_end;

  assign at_mid = tick && (os_cnt == MID_C);
  assign at_end = tick && (os_cnt == LAST_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      sync1 <= rxd_raw;
      rxd_s <= sync1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      os_cnt      <= '0;
      bit_idx     <= '0;
      data        <= '0;
      ninth       <= 1'b0;
      stop_ok     <= 1'b1;
      done        <= 1'b0;
      false_start <= 1'b0;
      prev        <= 1'b1;
    end else begin
      done        <= 1'b0;
      false_start <= 1'b0;
      if (tick) prev <= rxd_s;
      case (state)
        ST_IDLE: begin
          if (tick && prev && !rxd_s) begin
            state  <= ST_START;
            os_cnt <= '0;
          end
        end
        ST_START: begin
          if (at_mid) begin
            os_cnt <= '0;
            if (!rxd_s) begin
              state   <= ST_DATA;
              bit_idx <= '0;
            end else begin
              state       <= ST_IDLE;
              false_start <= 1'b1;
            end
          end else if (tick) os_cnt <= os_cnt + 1'b1;
        end
        ST_DATA: begin
          if (at_end) begin
            os_cnt <= '0;
            data   <= {rxd_s, data[DW-1:1]};
            if (bit_idx == TOP_B) state <= ninth_en ? ST_NINTH : ST_STOP;
            else bit_idx <= bit_idx + 1'b1;
          end else if (tick) os_cnt <= os_cnt + 1'b1;
        end
        ST_NINTH: begin
          if (at_end) begin
            os_cnt <= '0;
            ninth  <= rxd_s;
            state  <= ST_STOP;
          end else if (tick) os_cnt <= os_cnt + 1'b1;
        end
        ST_STOP: begin
          if (at_end) begin
            os_cnt  <= '0;
            stop_ok <= rxd_s;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else if (tick) os_cnt <= os_cnt + 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs485_rx_fifo.sv
module rs485_rx_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [DW-1:0]              wdata,
  input  logic                       pop,
  output logic [DW-1:0]              rdata,
  output logic [$clog2(DEPTH+1)-1:0] level,
  output logic                       full,
  output logic                       empty,
  output logic                       drop
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned LW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] PTR_TOP = AW'(DEPTH - 1);
  localparam logic [LW-1:0] LVL_MAX = LW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full    = (level == LVL_MAX);
  assign empty   = (level == '0);
  assign do_pop  = pop && !empty;
  assign do_push = push && (!full || do_pop);
  assign drop    = push && full && !do_pop;
  assign rdata   = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else begin
      if (do_push) begin
        mem[wr_ptr] <= wdata;
        wr_ptr <= (wr_ptr == PTR_TOP) ? '0 : wr_ptr + 1'b1;
      end
      if (do_pop) rd_ptr <= (rd_ptr == PTR_TOP) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end
endmodule

// File: rtl/rs485_addr_rx.sv
module rs485_addr_rx
  import rs485_rx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned DIV_W      = 16,
  parameter int unsigned FIFO_DEPTH = 4
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            rxd,
  input  logic                            cfg_par_en,
  input  logic                            cfg_even,
  input  logic                            cfg_stick,
  input  logic [DIV_W-1:0]                cfg_div,
  input  logic                            rd_en,
  output logic [RX_DW-1:0]                rd_data,
  output logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  output logic                            fifo_empty,
  output logic                            fifo_full,
  output logic                            addr_valid,
  output logic [RX_DW-1:0]                addr_data,
  output logic                            par_err,
  output logic                            frame_err,
  output logic                            overflow
);
  logic             tick;
  logic             rx_done, rx_ninth, rx_stop_ok, rx_false_start;
  logic [RX_DW-1:0] rx_data;
  logic             ninth_miss, is_addr, fifo_push, fifo_drop;

  rs485_rx_baud #(.DIV_W(DIV_W)) baud_i (
    .clk(clk), .rst_n(rst_n), .div(cfg_div), .tick(tick)
  );

  rs485_rx_deser #(.OSR(OSR), .DW(RX_DW)) deser_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd_raw(rxd), .ninth_en(cfg_par_en),
    .done(rx_done), .data(rx_data), .ninth(rx_ninth), .stop_ok(rx_stop_ok),
    .false_start(rx_false_start)
  );

  // routing decision for a finished character
  assign ninth_miss = cfg_par_en && (rx_ninth != want_ninth(rx_data, cfg_even, cfg_stick));
  assign is_addr    = rx_done && addr_mode(cfg_par_en, cfg_even, cfg_stick) && ninth_miss;
  assign fifo_push  = rx_done && !is_addr;

  rs485_rx_fifo #(.DEPTH(FIFO_DEPTH), .DW(RX_DW)) fifo_i (
    .clk(clk), .rst_n(rst_n), .push(fifo_push), .wdata(rx_data), .pop(rd_en),
    .rdata(rd_data), .level(fifo_level), .full(fifo_full), .empty(fifo_empty),
    .drop(fifo_drop)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_valid <= 1'b0;
      addr_data  <= '0;
      par_err    <= 1'b0;
      frame_err  <= 1'b0;
      overflow   <= 1'b0;
    end else begin
      addr_valid <= is_addr;
      if (is_addr) addr_data <= rx_data;
      if (rx_done) begin
        par_err   <= ninth_miss;
        frame_err <= !rx_stop_ok;
      end
      if (fifo_drop) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/rs485_addr_rx_chk.sv
module rs485_addr_rx_chk #(
  parameter int unsigned FIFO_DEPTH = 4
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            cfg_par_en,
  input logic                            cfg_even,
  input logic                            cfg_stick,
  input logic [$clog2(FIFO_DEPTH+1)-1:0] fifo_level,
  input logic                            fifo_empty,
  input logic                            fifo_full,
  input logic                            addr_valid,
  input logic                            overflow,
  input logic                            rx_false_start
);
  a_r4_addr_not_queued: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> fifo_level <= $past(fifo_level));

  a_r4_addr_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |=> !addr_valid);

  a_r4_addr_needs_mode: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> $past(cfg_par_en && cfg_even && cfg_stick));

  a_r6_no_addr_without_parity: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!cfg_par_en) |-> !addr_valid);

  a_r3_false_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rx_false_start |=> !addr_valid && fifo_level <= $past(fifo_level));

  a_r10_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= FIFO_DEPTH);

  a_r10_full_not_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !(fifo_full && fifo_empty));

  a_r11_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r11_overflow_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(fifo_full));
endmodule

bind rs485_addr_rx rs485_addr_rx_chk #(.FIFO_DEPTH(FIFO_DEPTH)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
  .cfg_stick(cfg_stick), .fifo_level(fifo_level), .fifo_empty(fifo_empty),
  .fifo_full(fifo_full), .addr_valid(addr_valid), .overflow(overflow),
  .rx_false_start(rx_false_start)
);

// File: tb/rs485_addr_rx_tb.sv
module rs485_addr_rx_tb_top;
  localparam int BITCLK = 32;  // 16 ticks, one tick every 2 clocks

  logic       clk = 1'b0, rst_n = 1'b0, rxd = 1'b1;
  logic       cfg_par_en = 1'b0, cfg_even = 1'b0, cfg_stick = 1'b0, rd_en = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic [7:0] rd_data, addr_data;
  logic [2:0] fifo_level;
  logic       fifo_empty, fifo_full, addr_valid, par_err, frame_err, overflow;

  int checks = 0, errors = 0;
  bit finished = 0;
  byte unsigned q_data[$];
  byte unsigned q_addr[$];
  bit m_par = 0, m_frm = 0, m_ovf = 0;

  always #2 clk = ~clk;

  rs485_addr_rx dut_i (
    .clk(clk), .rst_n(rst_n), .rxd(rxd), .cfg_par_en(cfg_par_en), .cfg_even(cfg_even),
    .cfg_stick(cfg_stick), .cfg_div(cfg_div), .rd_en(rd_en), .rd_data(rd_data),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .addr_valid(addr_valid), .addr_data(addr_data), .par_err(par_err),
    .frame_err(frame_err), .overflow(overflow)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // per-clock comparison of the address strobe against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      if (addr_valid) begin
        if (q_addr.size() == 0) check("R4 unexpected addr_valid", 1, 0);
        else check("R4 addr_data", addr_data, q_addr.pop_front());
      end
      if (fifo_level > 3'd4) check("R10 level bound", fifo_level, 4);
    end
  end

  function automatic bit model_ninth(input byte unsigned d);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += d[i];
    if (cfg_stick) return cfg_even ? 1'b0 : 1'b1;
    if (cfg_even) return (ones % 2) == 1;
    return (ones % 2) == 0;
  endfunction

  task automatic send(input byte unsigned d, input bit nb, input bit sb);
    bit miss;
    miss = cfg_par_en && (nb != model_ninth(d));
    m_par = miss;
    m_frm = !sb;
    if (cfg_par_en && cfg_even && cfg_stick && miss) q_addr.push_back(d);
    else if (q_data.size() == 4) m_ovf = 1;
    else q_data.push_back(d);
    @(negedge clk);
    rxd = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (BITCLK) @(negedge clk); end
    if (cfg_par_en) begin rxd = nb; repeat (BITCLK) @(negedge clk); end
    rxd = sb; repeat (BITCLK) @(negedge clk);
    rxd = 1'b1; repeat (2*BITCLK) @(negedge clk);
  endtask

  task automatic after_frame(input string req);
    check({req, " level"}, fifo_level, q_data.size());
    check({req, " addr consumed"}, q_addr.size(), 0);
    check({req, " par_err (R8)"}, par_err, m_par);
    check({req, " frame_err (R9)"}, frame_err, m_frm);
    check({req, " overflow"}, overflow, m_ovf);
  endtask

  task automatic read_one(input string req);
    @(negedge clk);
    if (q_data.size() == 0) check({req, " read from empty model"}, 1, 0);
    else check({req, " rd_data"}, rd_data, q_data.pop_front());
    rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic set_cfg(input bit pe, input bit ev, input bit st);
    cfg_par_en = pe; cfg_even = ev; cfg_stick = st;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    check("R1 level", fifo_level, 0);
    check("R1 empty", fifo_empty, 1);
    check("R1 addr_valid", addr_valid, 0);
    check("R1 flags", {par_err, frame_err, overflow}, 0);

    // R6 / R2: 8N1, bit order
    set_cfg(0, 0, 0);
    send(8'hA5, 0, 1); after_frame("R6 a5");
    send(8'h3C, 0, 1); after_frame("R2 3c");
    read_one("R2"); read_one("R10");
    @(negedge clk); rd_en = 1'b1; @(negedge clk); rd_en = 1'b0;
    check("R10 read on empty ignored", fifo_level, 0);

    // R4 / R5: address mode
    set_cfg(1, 1, 1);
    send(8'h12, 1, 1); after_frame("R4 address");
    send(8'h34, 0, 1); after_frame("R5 data");
    read_one("R5");

    // R7: parity checked, no address detection
    set_cfg(1, 1, 0);
    send(8'h07, 0, 1); after_frame("R7 even miss");
    send(8'h07, 1, 1); after_frame("R7 even ok");
    set_cfg(1, 0, 0);
    send(8'h0F, 0, 1); after_frame("R7 odd miss");
    set_cfg(1, 0, 1);
    send(8'h81, 0, 1); after_frame("R7 stick-one miss");
    repeat (4) read_one("R7");

    // R9: framing, alone and together with an address mark
    set_cfg(0, 0, 0);
    send(8'h5A, 0, 0); after_frame("R9 frame data");
    send(8'h66, 0, 1); after_frame("R9 frame clear");
    set_cfg(1, 1, 1);
    send(8'h99, 1, 0); after_frame("R9 R4 frame with address");
    read_one("R9"); read_one("R9");

    // R3: false start
    @(negedge clk); rxd = 1'b0; repeat (6) @(negedge clk); rxd = 1'b1;
    repeat (4*BITCLK) @(negedge clk);
    after_frame("R3 false start");
    send(8'hC3, 0, 1); after_frame("R3 recovery");

    // address strobe and queue read in the same cycle
    fork
      send(8'h44, 1, 1);
      begin
        @(posedge addr_valid); @(negedge clk);
        rd_en = 1'b1;
        check("R10 R4 rd_data during strobe", rd_data, q_data.pop_front());
        @(negedge clk); rd_en = 1'b0;
      end
    join
    after_frame("R4 R10 strobe plus read");
    check("R10 empty after read", fifo_empty, 1);

    // R11: overflow
    set_cfg(0, 0, 0);
    for (int k = 0; k < 5; k++) send(byte'(8'h10 + k), 0, 1);
    after_frame("R11 overflow");
    check("R11 full", fifo_full, 1);
    repeat (4) read_one("R11 retained order");
    check("R11 overflow sticky", overflow, 1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule